// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host end of a one-wire serialized interrupt bus and runs on the bus clock. The shared line is open to several drivers, so it appears here as three signals: an output enable, the value driven while enabled, and the level seen on the wire. The host frames each bus cycle. It drives a start pulse, then releases the line for seventeen data frames of three clocks each. Peripherals pull the line low in the sample clock of their own frame. Frames 0 to 15 carry interrupt lines 0 to 15, and frame 16 carries the channel-check condition. The host closes the cycle with a stop pulse, and the width of that pulse tells every peripheral which start mode applies next.

There are two start modes. In continuous mode the host begins every cycle itself after a programmable number of idle clocks. In quiet mode the host waits, released, until a peripheral pulls the idle line low for one clock. The host then takes over the low drive on the next clock. The controller is a single state machine with these states:

- ST_IDLE: line released.
- ST_START_LOW: start pulse driven low.
- ST_START_HIGH: one clock driven high.
- ST_START_TA: released turn-around.
- ST_FRAME: frame engine, with phases PH_SAMPLE, PH_RECOVER and PH_TURN.
- ST_STOP_LOW: stop pulse driven low.
- ST_STOP_HIGH: one clock driven high.
- ST_STOP_TA: released turn-around.

The transitions are:

- ST_IDLE to ST_START_LOW: the idle gap has elapsed in continuous mode, or a peripheral pulled the line low in quiet mode.
- ST_START_LOW to ST_START_HIGH: the low count has run out.
- ST_START_HIGH to ST_START_TA, then ST_START_TA to ST_FRAME at frame 0.
- Within ST_FRAME: PH_SAMPLE to PH_RECOVER to PH_TURN, then the next frame's PH_SAMPLE.
- ST_FRAME to ST_STOP_LOW: the PH_TURN of frame 16 ends. The next mode and the new status vector are taken here.
- ST_STOP_LOW to ST_STOP_HIGH: the stop count has run out.
- ST_STOP_HIGH to ST_STOP_TA, then ST_STOP_TA to ST_IDLE.

Top module: `sirq_host`

## Requirements
- R1: While reset is held and right after it, the line is released (line_oe = 0), irq_status is all zero and the mode is continuous. The first cycle therefore starts without any peripheral action.
- R2: In continuous mode the host drives the line low after cfg_idle_gap+1 released idle clocks. It holds the line low for L+1 clocks, where L is cfg_start_len with values below 3 treated as 3.
- R3: In quiet mode the idle line stays released indefinitely. When the line is low for one idle clock, the host drives it low from the very next clock, for L clocks, so the total low time is L+1.
- R4: The clock after the start pulse is driven high (line_oe = 1, line_out = 1). The clock after that is released, and frame 0 begins the clock after the release.
- R5: Seventeen frames follow back to back, each three clocks long in the order sample, recovery, turn-around. The host keeps the line released during all of them.
- R6: Bit k of irq_status is 1 exactly when the line was low in the sample clock of frame k, with bit 16 being the channel-check frame. All bits update together on the first stop clock and hold until the next cycle's stop.
- R7: The stop pulse is 2 low clocks if cfg_quiet is 1 at the end of the last frame, and 3 low clocks otherwise. It is followed by one driven-high clock and one released clock. The cycles that follow use the mode the stop pulse selected.
- R8: During an active cycle, a low level outside a sample clock changes neither the frame timing nor any status bit, and it does not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_quiet | input | 1 | Mode the next stop pulse selects: 1 quiet, 0 continuous |
| cfg_start_len | input | 3 | Host low clocks of the start pulse (3..7, smaller values act as 3) |
| cfg_idle_gap | input | 8 | Idle clocks minus one before a self-started cycle |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | Host drives the line when 1 |
| line_out | output | 1 | Level driven when line_oe is 1 (1 when released) |
| irq_status | output | 17 | Latched frame levels, 1 = asserted (low on the line) |

## Verification
A wrong state or counter shows up on line_oe and line_out within the same cycle. It appears as a start or stop pulse that is one clock too long or too short, a missing high clock, or a drive during a frame. A misaligned frame index or phase is not visible until the stop pulse, up to 51 clocks later. At that point irq_status shows asserted bits moved to a neighbouring position, or the stop pulse arrives early or late. A wrongly latched mode shows up in the next idle period, as a self-start in quiet mode or a missing self-start in continuous mode.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LOW,
        ST_START_HIGH,
        ST_START_TA,
        ST_FRAME,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_TA
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } frame_phase_e;

    localparam int unsigned MIN_START_LEN = 3;

endpackage

// File: rtl/sirq_sampler.sv
module sirq_sampler #(
    parameter int unsigned NUM_FRAMES = 17,
    localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic [IDX_W-1:0]      frame_idx,
    input  logic                  line_in,
    input  logic                  commit,
    output logic [NUM_FRAMES-1:0] status
);

    logic [NUM_FRAMES-1:0] shadow;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g] <= 1'b0;
            end else if (sample_en && frame_idx == IDX_W'(g)) begin
                shadow[g] <= ~line_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (commit) begin
            status <= shadow;
        end
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(status)); // R6

endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 17,
    parameter int unsigned LEN_W      = 3,
    parameter int unsigned GAP_W      = 8,
    localparam int unsigned IDX_W     = $clog2(NUM_FRAMES),
    localparam int unsigned CNT_W     = (GAP_W > LEN_W + 1) ? GAP_W : LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_quiet,
    input  logic [LEN_W-1:0] cfg_start_len,
    input  logic [GAP_W-1:0] cfg_idle_gap,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    output logic             sample_en,
    output logic [IDX_W-1:0] frame_idx,
    output logic             commit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    sirq_state_e      state, state_n;
    frame_phase_e     ph, ph_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [IDX_W-1:0] idx_n;
    logic             mode_quiet, mode_quiet_n;
    logic [LEN_W-1:0] eff_len;

    assign eff_len = (cfg_start_len < LEN_W'(MIN_START_LEN)) ? LEN_W'(MIN_START_LEN)
                                                             : cfg_start_len;

    // next-state logic
    always_comb begin
        state_n      = state;
        ph_n         = ph;
        cnt_n        = cnt;
        idx_n        = frame_idx;
        mode_quiet_n = mode_quiet;
        unique case (state)
            ST_IDLE: begin
                if (mode_quiet ? !line_in : (cnt >= CNT_W'(cfg_idle_gap))) begin
                    state_n = ST_START_LOW;
                    cnt_n   = mode_quiet ? CNT_W'(eff_len) - CNT_W'(1) : CNT_W'(eff_len);
                end else if (!mode_quiet) begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_START_LOW: begin
                if (cnt == '0) state_n = ST_START_HIGH;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            ST_START_HIGH: state_n = ST_START_TA;
            ST_START_TA: begin
                state_n = ST_FRAME;
                idx_n   = '0;
                ph_n    = PH_SAMPLE;
            end
            ST_FRAME: begin
                unique case (ph)
                    PH_SAMPLE:  ph_n = PH_RECOVER;
                    PH_RECOVER: ph_n = PH_TURN;
                    PH_TURN: begin
                        if (frame_idx == LAST_IDX) begin
                            state_n      = ST_STOP_LOW;
                            mode_quiet_n = cfg_quiet;
                            cnt_n        = cfg_quiet ? CNT_W'(1) : CNT_W'(2);
                        end else begin
                            idx_n = frame_idx + IDX_W'(1);
                            ph_n  = PH_SAMPLE;
                        end
                    end
                    default: ph_n = PH_SAMPLE;
                endcase
            end
            ST_STOP_LOW: begin
                if (cnt == '0) state_n = ST_STOP_HIGH;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            ST_STOP_HIGH: state_n = ST_STOP_TA;
            ST_STOP_TA: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ph         <= PH_SAMPLE;
            cnt        <= '0;
            frame_idx  <= '0;
            mode_quiet <= 1'b0;
        end else begin
            state      <= state_n;
            ph         <= ph_n;
            cnt        <= cnt_n;
            frame_idx  <= idx_n;
            mode_quiet <= mode_quiet_n;
        end
    end

    // outputs
    always_comb begin
        line_oe   = (state == ST_START_LOW) || (state == ST_START_HIGH) ||
                    (state == ST_STOP_LOW)  || (state == ST_STOP_HIGH);
        line_out  = !((state == ST_START_LOW) || (state == ST_STOP_LOW));
        sample_en = (state == ST_FRAME) && (ph == PH_SAMPLE);
        commit    = (state == ST_FRAME) && (ph == PH_TURN) && (frame_idx == LAST_IDX);
    end

    AST_QUIET_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mode_quiet && !line_in) |=> (line_oe && !line_out)); // R3
    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mode_quiet && line_in) |=> !line_oe); // R3
    AST_HIGH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |=> !line_oe); // R4
    AST_FRAMES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME) |-> !line_oe); // R5
    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME) |-> (frame_idx <= LAST_IDX)); // R5
    AST_STOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_LOW) |-> (cnt <= (mode_quiet ? CNT_W'(1) : CNT_W'(2)))); // R7

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
    parameter int unsigned NUM_FRAMES = 17,
    parameter int unsigned LEN_W      = 3,
    parameter int unsigned GAP_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_quiet,
    input  logic [LEN_W-1:0]      cfg_start_len,
    input  logic [GAP_W-1:0]      cfg_idle_gap,
    input  logic                  line_in,
    output logic                  line_oe,
    output logic                  line_out,
    output logic [NUM_FRAMES-1:0] irq_status
);

    localparam int unsigned IDX_W = $clog2(NUM_FRAMES);

    logic             sample_en;
    logic             commit;
    logic [IDX_W-1:0] frame_idx;

    sirq_fsm #(
        .NUM_FRAMES (NUM_FRAMES),
        .LEN_W      (LEN_W),
        .GAP_W      (GAP_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_quiet     (cfg_quiet),
        .cfg_start_len (cfg_start_len),
        .cfg_idle_gap  (cfg_idle_gap),
        .line_in       (line_in),
        .line_oe       (line_oe),
        .line_out      (line_out),
        .sample_en     (sample_en),
        .frame_idx     (frame_idx),
        .commit        (commit)
    );

    sirq_sampler #(
        .NUM_FRAMES (NUM_FRAMES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .frame_idx (frame_idx),
        .line_in   (line_in),
        .commit    (commit),
        .status    (irq_status)
    );

endmodule

// File: tb/sirq_host_test.sv
module sirq_host_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_quiet = 1'b0;
    logic [2:0]  cfg_start_len = 3'd3;
    logic [7:0]  cfg_idle_gap = 8'd0;
    logic        bus_drv = 1'b1;
    logic        line_in;
    logic        line_oe;
    logic        line_out;
    logic [16:0] irq_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    assign line_in = line_oe ? line_out : bus_drv;

    sirq_host uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_quiet     (cfg_quiet),
        .cfg_start_len (cfg_start_len),
        .cfg_idle_gap  (cfg_idle_gap),
        .line_in       (line_in),
        .line_oe       (line_oe),
        .line_out      (line_out),
        .irq_status    (irq_status)
    );

    // {start_len, idle_gap, asserted frames, expected low width}
    localparam logic [31:0] TABLE [0:5] = '{
        {3'd3, 8'd0, 17'h00000, 4'd4},
        {3'd5, 8'd2, 17'h1FFFF, 4'd6},
        {3'd7, 8'd5, 17'h05555, 4'd8},
        {3'd0, 8'd1, 17'h10001, 4'd4},
        {3'd4, 8'd3, 17'h08000, 4'd5},
        {3'd6, 8'd0, 17'h12345, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic run_cycle(input bit quiet_start, input bit glitch, input logic [16:0] vec,
                             input int exp_low, input int exp_stop,
                             input bit check_idle, input int exp_idle);
        int idle = 0;
        int low  = 0;
        int slow = 0;
        if (quiet_start) begin
            bus_drv = 1'b0;
            @(negedge clk);
            bus_drv = 1'b1;
            chk(line_oe && !line_out, "R3 takeover next clock", {line_oe, line_out}, 2);
            low = 1;
        end else begin
            while (!(line_oe && !line_out) && idle < 400) begin
                idle++;
                @(negedge clk);
            end
            if (check_idle) chk(idle == exp_idle, "R2 idle gap", idle, exp_idle);
        end
        while (line_oe && !line_out && low < 20) begin
            low++;
            @(negedge clk);
        end
        chk(low == exp_low, quiet_start ? "R3 start width" : "R2 start width", low, exp_low);
        chk(line_oe && line_out, "R4 high clock", {line_oe, line_out}, 3);
        @(negedge clk);
        chk(!line_oe, "R4 release", line_oe, 0);
        @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            chk(!line_oe, "R5 frame released", line_oe, 0);
            bus_drv = vec[i] ? 1'b0 : 1'b1;
            @(negedge clk);
            bus_drv = (glitch && (i == 5 || i == 9)) ? 1'b0 : 1'b1; // R8 low in recovery
            @(negedge clk);
            bus_drv = (glitch && i == 12) ? 1'b0 : 1'b1;            // R8 low in turn-around
            @(negedge clk);
            bus_drv = 1'b1;
        end
        while (line_oe && !line_out && slow < 10) begin
            slow++;
            @(negedge clk);
        end
        chk(slow == exp_stop, glitch ? "R8 stop width after stray lows" : "R7 stop width",
            slow, exp_stop);
        chk(line_oe && line_out, "R7 stop high", {line_oe, line_out}, 3);
        @(negedge clk);
        chk(!line_oe, "R7 stop release", line_oe, 0);
        chk(irq_status == vec, glitch ? "R8 status unaffected" : "R6 status", irq_status, vec);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!line_oe, "R1 released in reset", line_oe, 0);
        chk(irq_status == 17'h0, "R1 status zero", irq_status, 0);
        rst_n = 1'b1;

        // table-driven continuous cycles, R2 R5 R6 R7
        for (int t = 0; t < 6; t++) begin
            cfg_start_len = TABLE[t][31:29];
            cfg_idle_gap  = TABLE[t][28:21];
            cfg_quiet     = 1'b0;
            run_cycle(1'b0, 1'b0, TABLE[t][20:4], int'(TABLE[t][3:0]), 3,
                      t != 0, int'(TABLE[t][28:21]) + 1);
        end

        // switch to quiet via a 2-clock stop (R7)
        cfg_start_len = 3'd4;
        cfg_idle_gap  = 8'd1;
        cfg_quiet     = 1'b1;
        run_cycle(1'b0, 1'b0, 17'h0F0F0, 5, 2, 1'b1, 2);

        // quiet idle: no self start (R3)
        begin
            int drove = 0;
            for (int k = 0; k < 40; k++) begin
                if (line_oe) drove++;
                @(negedge clk);
            end
            chk(drove == 0, "R3 quiet stays idle", drove, 0);
        end

        // quiet start with stray lows during the cycle (R3 R8)
        cfg_start_len = 3'd5;
        run_cycle(1'b1, 1'b1, 17'h10420, 6, 2, 1'b0, 0);

        // quiet start, clamped length, back to continuous (R3 R7)
        repeat (3) @(negedge clk);
        cfg_start_len = 3'd1;
        cfg_quiet     = 1'b0;
        run_cycle(1'b1, 1'b0, 17'h00001, 4, 3, 1'b0, 0);

        // continuous again: host self starts (R7 R2)
        cfg_start_len = 3'd7;
        cfg_idle_gap  = 8'd2;
        run_cycle(1'b0, 1'b0, 17'h00000, 8, 3, 1'b1, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule